// File: doc/BRIEF.md
# Parallel Port Multi-Mode Byte FIFO

This block is the byte queue that sits between a host register interface and the handshake engines of a parallel port. A 3-bit mode code and a direction bit decide who may put bytes in and who may take them out. In the compatible FIFO mode the host fills the queue and the peripheral-side strobe engine drains it. In the extended-capability mode the queue runs toward the peripheral when the direction bit is 0 and toward the host when it is 1. In the test mode the host both fills and drains the queue itself, and the handshake side is cut off.

The block reports full, empty and a service flag. The service flag tells software that the queue has either room for a burst or a burst waiting. Its threshold depends on which way the data flows. A mode code that names no FIFO mode holds the queue flushed. The peripheral side gets a show-ahead head byte with a pop strobe, and a push strobe with a data byte. The engines that drive those strobes live outside this block.

Top module: `pport_fifo`

## Requirements
- R1: After reset the queue is empty and not full, `host_rdata` is 00h, and `svc_irq` is 0 while `mode` is 000.
- R2: In mode 010 a host write enqueues a byte, `per_pop_data` shows the head byte, and `per_pop` dequeues it. The direction bit is treated as 0. `host_rd` and `per_push` have no effect on the contents or on `host_rdata`.
- R3: In mode 011 with `dir`=0, host writes are queued and drained by `per_pop`. With `dir`=1, `per_push` bytes are queued and drained by host reads, and host writes and `per_pop` are ignored.
- R4: In mode 110 the host may both write and read in either direction, and `per_pop` and `per_push` change nothing.
- R5: A host write while the queue holds 16 bytes is discarded, and the contents and ordering are unchanged.
- R6: A host read of an empty queue in a read-enabled mode returns the previously returned byte again and leaves the queue empty.
- R7: Bytes leave in the order they entered. For example, 44h, 33h, 22h written are read back as 44h, 33h, 22h. Host read data appears on `host_rdata` one clock after the `host_rd` strobe.
- R8: `svc_irq` is 1 when the effective direction is 0 and at least 8 of the 16 entries are free, or when it is 1 and at least 8 entries are filled. It is 0 in modes other than 010, 011 and 110.
- R9: While `mode` is not 010, 011 or 110, the queue is flushed to empty and `host_rdata` is cleared to 00h.
- R10: A fill access and a drain access in the same cycle both complete, and the occupancy stays correct. In an empty queue, the read returns the previous byte and the written byte is kept.
- R11: `full` and `empty` are never asserted together and always match the true occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Port mode code (010 compatible FIFO, 011 extended, 110 test) |
| dir | input | 1 | Direction: 0 toward peripheral, 1 toward host |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_rdata | output | 8 | Byte returned by the last host read |
| per_pop | input | 1 | Peripheral-side dequeue strobe |
| per_pop_data | output | 8 | Head byte offered to the peripheral side |
| per_push | input | 1 | Peripheral-side enqueue strobe |
| per_push_data | input | 8 | Byte enqueued by the peripheral side |
| full | output | 1 | Queue holds 16 bytes |
| empty | output | 1 | Queue holds no bytes |
| svc_irq | output | 1 | Service threshold flag |

## Verification
A wrong pointer or occupancy count shows at the ports within one read. Either a byte comes back out of order, or `full`/`empty` disagree with the number of accepted writes, and draining the queue exposes the difference byte by byte. A bad empty-read path shows on the next `host_rdata` sample as a changed value instead of a repeat. A wrong threshold compare moves the `svc_irq` edge by one entry, and this is visible when the queue is filled or drained one byte at a time.

// File: rtl/pport_fifo_pkg.sv
package pport_fifo_pkg;
  typedef logic [2:0] pp_mode_t;

  localparam pp_mode_t PP_MODE_COMPAT = 3'b010;
  localparam pp_mode_t PP_MODE_EXT    = 3'b011;
  localparam pp_mode_t PP_MODE_TEST   = 3'b110;

  // one cycle's worth of decoded queue actions
  typedef struct packed {
    logic flush;
    logic push;
    logic push_per;   // 1: fill data comes from the peripheral side
    logic pop;
    logic host_take;  // a host read is served this cycle
    logic svc_en;
    logic svc_dir;
  } pp_access_t;
endpackage

// File: rtl/pport_fifo_ctrl.sv
module pport_fifo_ctrl
  import pport_fifo_pkg::*;
(
  input  pp_mode_t   mode,
  input  logic       dir,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       per_pop,
  input  logic       per_push,
  input  logic       full,
  input  logic       empty,
  output pp_access_t acc
);
  logic m_compat, m_ext, m_test, valid_mode;
  logic host_fill_ok, per_fill_ok, per_drain_ok, host_drain_ok;

  always_comb begin
    m_compat   = (mode == PP_MODE_COMPAT);
    m_ext      = (mode == PP_MODE_EXT);
    m_test     = (mode == PP_MODE_TEST);
    valid_mode = m_compat | m_ext | m_test;

    host_fill_ok  = m_compat | (m_ext & ~dir) | m_test;
    per_fill_ok   = m_ext & dir;
    per_drain_ok  = m_compat | (m_ext & ~dir);
    host_drain_ok = (m_ext & dir) | m_test;

    acc.flush     = ~valid_mode;
    acc.push_per  = per_fill_ok;
    acc.push      = ~full & ((host_fill_ok & host_wr) | (per_fill_ok & per_push));
    acc.host_take = host_drain_ok & host_rd;
    acc.pop       = ~empty & ((per_drain_ok & per_pop) | (host_drain_ok & host_rd));
    acc.svc_en    = valid_mode;
    acc.svc_dir   = m_compat ? 1'b0 : dir;
  end
endmodule

// File: rtl/pport_fifo_store.sv
module pport_fifo_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_d, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push) wr_ptr_d = bump(wr_ptr_q);
      if (pop)  rd_ptr_d = bump(rd_ptr_q);
      case ({push, pop})
        2'b10:   count_d = count_q + CW'(1);
        2'b01:   count_d = count_q - CW'(1);
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  // storage array carries no reset; only written entries are ever read
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr_q] <= push_data;
  end

  assign head  = mem[rd_ptr_q];
  assign count = count_q;
endmodule

// File: rtl/pport_fifo_flags.sv
module pport_fifo_flags #(
  parameter int DEPTH   = 16,
  parameter int WR_FREE = 8,
  parameter int RD_FILL = 8,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  input  logic          svc_en,
  input  logic          svc_dir,
  output logic          full,
  output logic          empty,
  output logic          svc
);
  logic [CW-1:0] free_cnt;

  always_comb begin
    free_cnt = CW'(DEPTH) - count;
    full     = (count == CW'(DEPTH));
    empty    = (count == '0);
    if (!svc_en)      svc = 1'b0;
    else if (svc_dir) svc = (count >= CW'(RD_FILL));
    else              svc = (free_cnt >= CW'(WR_FREE));
  end
endmodule

// File: rtl/pport_fifo.sv
module pport_fifo
  import pport_fifo_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DEPTH   = 16,
  parameter int WR_FREE = 8,
  parameter int RD_FILL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic          dir,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          per_pop,
  output logic [DW-1:0] per_pop_data,
  input  logic          per_push,
  input  logic [DW-1:0] per_push_data,
  output logic          full,
  output logic          empty,
  output logic          svc_irq
);
  localparam int CW = $clog2(DEPTH + 1);

  pp_access_t    acc;
  logic [CW-1:0] occ_count;
  logic [DW-1:0] head, fill_data;
  logic [DW-1:0] rdata_q, rdata_d;

  pport_fifo_ctrl u_ctrl (
    .mode     (mode),
    .dir      (dir),
    .host_wr  (host_wr),
    .host_rd  (host_rd),
    .per_pop  (per_pop),
    .per_push (per_push),
    .full     (full),
    .empty    (empty),
    .acc      (acc)
  );

  assign fill_data = acc.push_per ? per_push_data : host_wdata;

  pport_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (acc.flush),
    .push      (acc.push),
    .push_data (fill_data),
    .pop       (acc.pop),
    .head      (head),
    .count     (occ_count)
  );

  pport_fifo_flags #(.DEPTH(DEPTH), .WR_FREE(WR_FREE), .RD_FILL(RD_FILL)) u_flags (
    .count   (occ_count),
    .svc_en  (acc.svc_en),
    .svc_dir (acc.svc_dir),
    .full    (full),
    .empty   (empty),
    .svc     (svc_irq)
  );

  // host read register doubles as the last-read byte for empty reads
  always_comb begin
    rdata_d = rdata_q;
    if (acc.flush)                  rdata_d = '0;
    else if (acc.host_take && !empty) rdata_d = head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign host_rdata   = rdata_q;
  assign per_pop_data = head;
endmodule

// File: rtl/pport_fifo_chk.sv
module pport_fifo_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode,
  input logic          host_wr,
  input logic          host_rd,
  input logic          per_pop,
  input logic [DW-1:0] host_rdata,
  input logic          full,
  input logic          empty,
  input logic [CW-1:0] count
);
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r11_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r5_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b110 && full && host_wr && !host_rd) |=> (full && count == $past(count)));

  a_r6_empty_read_repeats: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b110 && empty && host_rd && !host_wr) |=> ($stable(host_rdata) && empty));

  a_r9_invalid_mode_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'b010 && mode != 3'b011 && mode != 3'b110) |=> (empty && host_rdata == '0));

  a_r4_test_ignores_peripheral: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b110 && !host_wr && !host_rd) |=> (count == $past(count)));

  a_r10_fill_drain_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b010 && host_wr && per_pop && !full && !empty) |=> (count == $past(count)));
endmodule

bind pport_fifo pport_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .per_pop    (per_pop),
  .host_rdata (host_rdata),
  .full       (full),
  .empty      (empty),
  .count      (occ_count)
);

// File: tb/pport_fifo_test.sv
module pport_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  logic       dir = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, per_pop = 1'b0, per_push = 1'b0;
  logic [7:0] host_wdata = 8'h00, per_push_data = 8'h00;
  logic [7:0] host_rdata, per_pop_data;
  logic       full, empty, svc_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pport_fifo uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dir(dir),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .per_pop(per_pop), .per_pop_data(per_pop_data), .per_push(per_push),
    .per_push_data(per_push_data), .full(full), .empty(empty), .svc_irq(svc_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m, input logic d);
    mode = m; dir = d; @(negedge clk);
  endtask
  task automatic hw(input logic [7:0] b);
    host_wr = 1'b1; host_wdata = b; @(negedge clk); host_wr = 1'b0;
  endtask
  task automatic hr();
    host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
  endtask
  task automatic pp();
    per_pop = 1'b1; @(negedge clk); per_pop = 1'b0;
  endtask
  task automatic pu(input logic [7:0] b);
    per_push = 1'b1; per_push_data = b; @(negedge clk); per_push = 1'b0;
  endtask
  task automatic flush();
    set_mode(3'b000, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 empty", {7'd0, empty}, 8'd1);
    chk("R1 full", {7'd0, full}, 8'd0);
    chk("R1 rdata", host_rdata, 8'h00);
    chk("R1 svc", {7'd0, svc_irq}, 8'd0);
  endtask

  task automatic t_compat();
    set_mode(3'b010, 1'b1);
    hw(8'hA1); hw(8'hA2);
    chk("R2 head", per_pop_data, 8'hA1);
    hr();
    chk("R2 host read ignored", host_rdata, 8'h00);
    pu(8'h5A);
    chk("R2 push ignored head", per_pop_data, 8'hA1);
    pp();
    chk("R2 drain", per_pop_data, 8'hA2);
    pp();
    chk("R2 empty after drain", {7'd0, empty}, 8'd1);
    flush();
  endtask

  task automatic t_ext();
    set_mode(3'b011, 1'b0);
    hw(8'hC1);
    chk("R3 fwd head", per_pop_data, 8'hC1);
    pp();
    chk("R3 fwd empty", {7'd0, empty}, 8'd1);
    set_mode(3'b011, 1'b1);
    pu(8'hB1); hw(8'hEE); pu(8'hB2); pp();
    hr(); chk("R3 rev first", host_rdata, 8'hB1);
    hr(); chk("R3 rev second", host_rdata, 8'hB2);
    chk("R3 rev empty", {7'd0, empty}, 8'd1);
    flush();
  endtask

  task automatic t_order();
    set_mode(3'b110, 1'b0);
    hw(8'h44); hw(8'h33); hw(8'h22);
    pp(); pu(8'h99);
    hr(); chk("R7 first", host_rdata, 8'h44);
    hr(); chk("R7 second", host_rdata, 8'h33);
    hr(); chk("R7 third", host_rdata, 8'h22);
    chk("R4 peripheral strobes ignored", {7'd0, empty}, 8'd1);
    flush();
  endtask

  task automatic t_full_empty();
    set_mode(3'b110, 1'b1);
    for (int i = 0; i < 16; i++) hw(8'h10 + 8'(i));
    chk("R11 full", {7'd0, full}, 8'd1);
    hw(8'hAA);
    chk("R5 still full", {7'd0, full}, 8'd1);
    for (int i = 0; i < 16; i++) begin
      hr();
      chk("R5 drain order", host_rdata, 8'h10 + 8'(i));
    end
    chk("R11 empty", {7'd0, empty}, 8'd1);
    hr();
    chk("R6 repeat", host_rdata, 8'h1F);
    chk("R6 still empty", {7'd0, empty}, 8'd1);
    flush();
  endtask

  task automatic t_irq();
    set_mode(3'b110, 1'b1);
    for (int i = 0; i < 7; i++) hw(8'(i));
    chk("R8 read thr below", {7'd0, svc_irq}, 8'd0);
    hw(8'h07);
    chk("R8 read thr met", {7'd0, svc_irq}, 8'd1);
    for (int i = 8; i < 16; i++) hw(8'(i));
    set_mode(3'b110, 1'b0);
    chk("R8 write thr full", {7'd0, svc_irq}, 8'd0);
    for (int i = 0; i < 7; i++) hr();
    chk("R8 write thr below", {7'd0, svc_irq}, 8'd0);
    hr();
    chk("R8 write thr met", {7'd0, svc_irq}, 8'd1);
    set_mode(3'b010, 1'b1);
    chk("R8 compat forces dir0", {7'd0, svc_irq}, 8'd1);
    set_mode(3'b111, 1'b0);
    chk("R8 off in other modes", {7'd0, svc_irq}, 8'd0);
    chk("R9 flushed", {7'd0, empty}, 8'd1);
    chk("R9 rdata cleared", host_rdata, 8'h00);
    set_mode(3'b110, 1'b0);
    hr();
    chk("R9 nothing left", host_rdata, 8'h00);
    flush();
  endtask

  task automatic t_simul();
    set_mode(3'b110, 1'b0);
    hw(8'h01); hw(8'h02); hw(8'h03);
    host_wr = 1'b1; host_wdata = 8'h04; host_rd = 1'b1; @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    chk("R10 read during write", host_rdata, 8'h01);
    hr(); hr(); hr();
    chk("R10 written kept", host_rdata, 8'h04);
    chk("R10 empty", {7'd0, empty}, 8'd1);
    host_wr = 1'b1; host_wdata = 8'h05; host_rd = 1'b1; @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    chk("R10 empty read repeats", host_rdata, 8'h04);
    chk("R10 byte accepted", {7'd0, empty}, 8'd0);
    hr();
    chk("R10 new byte", host_rdata, 8'h05);
    set_mode(3'b010, 1'b0);
    hw(8'h61);
    host_wr = 1'b1; host_wdata = 8'h62; per_pop = 1'b1; @(negedge clk);
    host_wr = 1'b0; per_pop = 1'b0;
    chk("R10 compat head", per_pop_data, 8'h62);
    pp();
    chk("R10 compat empty", {7'd0, empty}, 8'd1);
    flush();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_compat();
    t_ext();
    t_order();
    t_full_empty();
    t_irq();
    t_simul();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule